// File: doc/BRIEF.md
# Nibble-Bus Serial Interface Controller

This peripheral connects a 4-bit processor data bus to a serial line. Software reaches a byte-wide transmit buffer and a byte-wide receive buffer through one shared buffer address. Each byte takes two bus cycles. A write fills the low half of the byte first and the high half second. A read returns the high half first and the low half second. One internal pointer flip-flop decides which half the next buffer access reaches.

A second address holds a 4-bit register whose meaning depends on direction. Written, it sets the control bits: link enable (active low), acknowledge suppression, interrupt mask and interrupt source. Read, it returns the status: the last transmit acknowledge, whether a telegram is in progress, and the buffer-ready flag.

A telegram starts on a start strobe and moves one bit per shift-enable pulse, most significant bit first, through an 8-bit shift register. In link mode a ninth acknowledge slot follows the data. The block raises a single-cycle interrupt either when a telegram ends or when buffer-ready falls.

Top module: `nibser_ctrl`

## Requirements
- R1: After reset the written control bits are 1111b, so the link is off, no acknowledge is sent, the interrupt is masked and the interrupt source is telegram end. The status read (`bus_ctl`=1) then returns {0, transmit-ack=1, active=0, ready}, where ready=1 in receive mode. `ser_out` idles high and `irq` stays low.
- R2: Two buffer writes (`bus_ctl`=0) form one transmit byte. The first write supplies bits 3..0 and the second supplies bits 7..4. The second write marks the transmit buffer full, so status bit 0 reads 1 in transmit mode.
- R3: Two buffer reads form one received byte. The first read returns bits 7..4 and the second returns bits 3..0. The second read empties the buffer, so status bit 0 reads 1 again in receive mode.
- R4: Any control write returns the nibble pointer to the first half, so the next buffer access is again a first cycle.
- R5: In transmit mode, a start with a full buffer copies the buffer into the shift register, empties the buffer and sets status bit 1 (active). `ser_out` then presents bits 7 down to 0, advancing on each `shift_en` pulse.
- R6: In receive mode, `ser_in` is sampled on each `shift_en`, most significant bit first. The receive buffer and ready flag change only when the whole telegram has arrived.
- R7: In link mode (control bit 3 = 0), a transmit telegram has a ninth slot. During that slot `ser_out` is released high and `ser_in` is sampled into status bit 2: 0 means acknowledged, 1 means not acknowledged.
- R8: In link mode, a receive telegram has a ninth slot. During that slot `ser_out` drives control bit 2: 0 drives an acknowledge, 1 suppresses it.
- R9: With mask (control bit 1) = 0 and interrupt source (control bit 0) = 1, `irq` pulses for exactly one cycle after each telegram ends.
- R10: With mask = 0 and interrupt source = 0, `irq` pulses for one cycle after each falling edge of the ready flag. It does not pulse on a rising edge or at telegram end.
- R11: With mask = 1, no interrupt is produced. A control write whose bit 1 is 1 also suppresses a pulse in the same cycle.
- R12: A start in transmit mode while the transmit buffer is empty is ignored: the block stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ctl | input | 1 | Address select: 1 = control/status register, 0 = byte buffers |
| bus_wr | input | 1 | Bus write strobe, one cycle per nibble |
| bus_rd | input | 1 | Bus read strobe, one cycle per nibble |
| bus_wdata | input | 4 | Write nibble |
| bus_rdata | output | 4 | Read nibble (status or receive buffer half) |
| tx_mode | input | 1 | Direction: 1 = transmit, 0 = receive |
| tl_start | input | 1 | Start strobe for a telegram |
| shift_en | input | 1 | One bit-time per pulse |
| ser_in | input | 1 | Serial data and acknowledge input |
| ser_out | output | 1 | Serial data and acknowledge output |
| irq | output | 1 | Single-cycle serial interrupt |

## Verification
Every one of the 256 byte values is sent and every one is received. A swapped nibble order, a bit-order reversal or an off-by-one shift count shows up as a wrong byte for some value. Link-mode telegrams are run with an acknowledge present and absent in both directions, which separates the sampled status from the driven slot level. Interrupts are counted in five settings: end-source, ready-fall source, masked, masked by a write in the very cycle the event would fire, and data writes that raise ready. These settings show which event triggers a pulse and which are suppressed. A control write between nibble writes, a start with an empty buffer, and a status read in the middle of a receive telegram cover the pointer reset, the ignored start and the deferred buffer load.

// File: rtl/nibser_pkg.sv
package nibser_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int CNT_W  = $clog2(BYTE_W);

    // written meaning of the 4-bit control register (bit 3 down to 0)
    typedef struct packed {
        logic link_n;   // 0 = link mode with acknowledge slot
        logic rack_n;   // 0 = drive acknowledge in receive slot
        logic mask;     // 1 = interrupt disabled
        logic ifn_end;  // 1 = interrupt at telegram end, 0 = on ready fall
    } ctl_t;

    localparam ctl_t CTL_RESET = '{link_n: 1'b1, rack_n: 1'b1, mask: 1'b1, ifn_end: 1'b1};

    // read meaning of the same address
    typedef struct packed {
        logic spare;
        logic tack_n;
        logic active;
        logic ready;
    } stat_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_DATA = 2'd1,
        ENG_ACK  = 2'd2
    } eng_state_e;

    function automatic logic [BYTE_W-1:0] shl_in(input logic [BYTE_W-1:0] v, input logic b);
        return {v[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/nibser_regs.sv
module nibser_regs
    import nibser_pkg::*;
#(
    parameter int NW = NIB_W,
    localparam int BW = 2 * NW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_ctl,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [NW-1:0] wdata,
    input  logic          tx_take,
    input  logic          rx_load,
    input  logic [BW-1:0] rx_byte,
    output ctl_t          ctl,
    output logic [BW-1:0] tx_buf,
    output logic          tx_full,
    output logic          rx_full,
    output logic [NW-1:0] buf_rdata
);

    logic          ptr;      // 0 = first nibble cycle next
    logic [BW-1:0] rx_buf;
    logic          ctl_wr, buf_wr, buf_rd;

    assign ctl_wr = bus_wr & bus_ctl;
    assign buf_wr = bus_wr & ~bus_ctl;
    assign buf_rd = bus_rd & ~bus_ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= CTL_RESET;
            ptr     <= 1'b0;
            tx_buf  <= '0;
            tx_full <= 1'b0;
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else begin
            if (ctl_wr)
                ctl <= ctl_t'(wdata[3:0]);

            if (ctl_wr)
                ptr <= 1'b0;
            else if (buf_wr || buf_rd)
                ptr <= ~ptr;

            if (buf_wr) begin
                if (!ptr) tx_buf[NW-1:0]  <= wdata;
                else      tx_buf[BW-1:NW] <= wdata;
            end

            if (buf_wr && ptr)
                tx_full <= 1'b1;
            else if (tx_take)
                tx_full <= 1'b0;

            if (rx_load) begin
                rx_buf  <= rx_byte;
                rx_full <= 1'b1;
            end else if (buf_rd && ptr) begin
                rx_full <= 1'b0;
            end
        end
    end

    // receive side: high half on the first read, low half on the second
    assign buf_rdata = ptr ? rx_buf[NW-1:0] : rx_buf[BW-1:NW];

    assert_full_after_hi_write_R2: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && ptr) |=> tx_full);

    assert_take_empties_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_take && !(buf_wr && ptr)) |=> !tx_full);

    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !(buf_rd && ptr)) |=> rx_full);

endmodule

// File: rtl/nibser_shift.sv
module nibser_shift
    import nibser_pkg::*;
#(
    parameter int BW = BYTE_W,
    localparam int CW = $clog2(BW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_mode,
    input  logic          link_en,
    input  logic          rack_n,
    input  logic          start,
    input  logic          shift_en,
    input  logic          ser_in,
    input  logic          tx_full,
    input  logic [BW-1:0] tx_buf,
    output logic          ser_out,
    output logic          act,
    output logic          tx_take,
    output logic          fin,
    output logic [BW-1:0] rx_byte,
    output logic          tack_n
);

    eng_state_e    state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] sreg, shifted;
    logic          dir_tx, link_q;
    logic          go, last_bit;

    assign go       = (state == ENG_IDLE) && start && (!tx_mode || tx_full);
    assign tx_take  = go && tx_mode;
    assign last_bit = (state == ENG_DATA) && shift_en && (cnt == CW'(BW - 1));
    assign fin      = (last_bit && !link_q) || ((state == ENG_ACK) && shift_en);
    assign shifted  = shl_in(sreg, dir_tx ? 1'b0 : ser_in);
    assign rx_byte  = (state == ENG_ACK) ? sreg : shifted;
    assign act      = (state != ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            cnt    <= '0;
            sreg   <= '0;
            dir_tx <= 1'b0;
            link_q <= 1'b0;
            tack_n <= 1'b1;
        end else begin
            case (state)
                ENG_IDLE: if (go) begin
                    state  <= ENG_DATA;
                    cnt    <= '0;
                    sreg   <= tx_mode ? tx_buf : '0;
                    dir_tx <= tx_mode;
                    link_q <= link_en;
                end
                ENG_DATA: if (shift_en) begin
                    sreg <= shifted;
                    cnt  <= cnt + 1'b1;
                    if (cnt == CW'(BW - 1))
                        state <= link_q ? ENG_ACK : ENG_IDLE;
                end
                ENG_ACK: if (shift_en) begin
                    if (dir_tx) tack_n <= ser_in;
                    state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ENG_DATA: ser_out = dir_tx ? sreg[BW-1] : 1'b1;
            ENG_ACK:  ser_out = dir_tx ? 1'b1 : rack_n;
            default:  ser_out = 1'b1;
        endcase
    end

    assert_rx_start_R6: assert property (@(posedge clk) disable iff (rst)
        (!act && start && !tx_mode) |=> act);

    assert_empty_start_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (!act && start && tx_mode && !tx_full) |=> !act);

    assert_tack_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!act) |=> $stable(tack_n));

endmodule

// File: rtl/nibser_irq.sv
module nibser_irq
    import nibser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic ctl_wr,
    input  logic wr_mask_bit,
    input  logic ready,
    input  logic fin,
    output logic irq
);

    logic ready_q, done_q, fall, kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            ready_q <= ready;
            done_q  <= fin;
        end
    end

    assign fall = ready_q & ~ready;
    assign kill = ctl_wr & wr_mask_bit;
    assign irq  = ~ctl.mask & ~kill & (ctl.ifn_end ? done_q : fall);

    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ctl.mask |-> !irq);

    assert_end_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (fin && ctl.ifn_end && !ctl.mask && !ctl_wr) |=> (irq || ctl_wr));

endmodule

// File: rtl/nibser_ctrl.sv
module nibser_ctrl
    import nibser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_ctl,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [NIB_W-1:0] bus_wdata,
    output logic [NIB_W-1:0] bus_rdata,
    input  logic             tx_mode,
    input  logic             tl_start,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             irq
);

    ctl_t              ctl;
    stat_t             stat;
    logic [BYTE_W-1:0] tx_buf, rx_byte;
    logic [NIB_W-1:0]  buf_rdata;
    logic              tx_full, rx_full, tx_take, fin, act, tack_n, ready;

    nibser_regs #(.NW(NIB_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_ctl   (bus_ctl),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .wdata     (bus_wdata),
        .tx_take   (tx_take),
        .rx_load   (fin && !tx_mode_q_unused_guard(tx_mode)),
        .rx_byte   (rx_byte),
        .ctl       (ctl),
        .tx_buf    (tx_buf),
        .tx_full   (tx_full),
        .rx_full   (rx_full),
        .buf_rdata (buf_rdata)
    );

    nibser_shift #(.BW(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .tx_mode  (tx_mode),
        .link_en  (~ctl.link_n),
        .rack_n   (ctl.rack_n),
        .start    (tl_start),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .tx_full  (tx_full),
        .tx_buf   (tx_buf),
        .ser_out  (ser_out),
        .act      (act),
        .tx_take  (tx_take),
        .fin      (fin),
        .rx_byte  (rx_byte),
        .tack_n   (tack_n)
    );

    nibser_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .ctl_wr      (bus_wr && bus_ctl),
        .wr_mask_bit (bus_wdata[1]),
        .ready       (ready),
        .fin         (fin),
        .irq         (irq)
    );

    // the receive buffer loads only on a receive telegram end
    function automatic logic tx_mode_q_unused_guard(input logic m);
        return m;
    endfunction

    assign ready = tx_mode ? tx_full : ~rx_full;

    always_comb begin
        stat.spare  = 1'b0;
        stat.tack_n = tack_n;
        stat.active = act;
        stat.ready  = ready;
    end

    assign bus_rdata = bus_ctl ? NIB_W'(stat) : buf_rdata;

    assert_rdy_rx_R3: assert property (@(posedge clk) disable iff (rst)
        (!tx_mode && $past(!tx_mode) && $rose(rx_full)) |-> !ready);

endmodule

// File: tb/nibser_ctrl_test.sv
`timescale 1ns/100ps
module nibser_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_ctl = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_wdata = 4'h0;
    logic [3:0] bus_rdata;
    logic       tx_mode = 1'b0, tl_start = 1'b0, shift_en = 1'b0, ser_in = 1'b1;
    logic       ser_out, irq;

    int tests = 0, fails = 0, irq_cnt = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    nibser_ctrl uut (
        .clk(clk), .rst(rst), .bus_ctl(bus_ctl), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_mode(tx_mode),
        .tl_start(tl_start), .shift_en(shift_en), .ser_in(ser_in),
        .ser_out(ser_out), .irq(irq)
    );

    always @(negedge clk) if (!rst && irq) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic c, input logic [3:0] d);
        @(posedge clk); #1 bus_ctl = c; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 1'b0; bus_ctl = 1'b0;
    endtask

    task automatic rd(input logic c, output logic [3:0] d);
        @(posedge clk); #1 bus_ctl = c; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0; bus_ctl = 1'b0;
    endtask

    task automatic start();
        @(posedge clk); #1 tl_start = 1'b1;
        @(posedge clk); #1 tl_start = 1'b0;
    endtask

    task automatic shift1(input logic bi, output logic bo);
        @(posedge clk); #1 ser_in = bi; shift_en = 1'b1;
        #1 bo = ser_out;
        @(posedge clk); #1 shift_en = 1'b0; ser_in = 1'b1;
    endtask

    task automatic send(input logic [7:0] b, output logic [7:0] got);
        logic bo;
        wr(1'b0, b[3:0]);
        wr(1'b0, b[7:4]);
        start();
        for (int i = 0; i < 8; i++) begin
            shift1(1'b0, bo);
            got = {got[6:0], bo};
        end
    endtask

    task automatic recv_bits(input logic [7:0] b);
        logic bo;
        start();
        for (int i = 7; i >= 0; i--) shift1(b[i], bo);
    endtask

    task automatic read_byte(output logic [7:0] got);
        logic [3:0] hi, lo;
        rd(1'b0, hi);
        rd(1'b0, lo);
        got = {hi, lo};
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #1000000;
        if (!done_flag) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] s;
        logic [7:0] got;
        logic       bo;
        int         base;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(1'b1, s);
        chk("R1 status after reset", s, 4'h5);
        chk("R1 idle line", ser_out, 1'b1);
        chk("R1 no irq", irq_cnt, 0);

        // R12 empty-buffer start ignored
        #0 tx_mode = 1'b1;
        start();
        rd(1'b1, s);
        chk("R12 active after empty start", s, 4'h4);

        // R2 R5 R9 full transmit sweep: link off, unmasked, end source
        wr(1'b1, 4'b1101);
        for (int v = 0; v < 256; v++) begin
            base = irq_cnt;
            wr(1'b0, v[3:0]);
            wr(1'b0, v[7:4]);
            rd(1'b1, s);
            chk("R2 ready after second write", {30'd0, s[1:0]}, 32'd1);
            start();
            rd(1'b1, s);
            chk("R5 active and emptied after start", {30'd0, s[1:0]}, 32'd2);
            for (int i = 0; i < 8; i++) begin
                shift1(1'b0, bo);
                got = {got[6:0], bo};
            end
            chk("R5 shifted byte msb first", got, v);
            rd(1'b1, s);
            chk("R5 idle after telegram", {30'd0, s[1:0]}, 32'd0);
            chk("R9 one end pulse", irq_cnt - base, 1);
        end

        // R4 pointer reset by control write
        wr(1'b0, 4'hA);
        wr(1'b1, 4'b1101);
        wr(1'b0, 4'h3);
        rd(1'b1, s);
        chk("R4 one nibble after ctl write not full", s[0], 1'b0);
        wr(1'b0, 4'hC);
        rd(1'b1, s);
        chk("R4 full after second nibble", s[0], 1'b1);
        start();
        for (int i = 0; i < 8; i++) begin
            shift1(1'b0, bo);
            got = {got[6:0], bo};
        end
        chk("R4 byte after pointer reset", got, 8'hC3);

        // R7 link transmit, acknowledge seen then missing
        wr(1'b1, 4'b0101);
        send(8'h96, got);
        shift1(1'b0, bo);
        chk("R7 slot released high", bo, 1'b1);
        chk("R7 link data", got, 8'h96);
        rd(1'b1, s);
        chk("R7 ack seen", s, 4'h0);
        send(8'h69, got);
        shift1(1'b1, bo);
        rd(1'b1, s);
        chk("R7 no ack", s, 4'h4);

        // R3 R6 R9 full receive sweep: link off
        #0 tx_mode = 1'b0;
        wr(1'b1, 4'b1101);
        for (int v = 0; v < 256; v++) begin
            base = irq_cnt;
            start();
            for (int i = 7; i >= 4; i--) shift1(v[i], bo);
            if (v == 8'hA5) begin
                rd(1'b1, s);
                chk("R6 buffer untouched mid telegram", {30'd0, s[1:0]}, 32'd3);
            end
            for (int i = 3; i >= 0; i--) shift1(v[i], bo);
            rd(1'b1, s);
            chk("R6 ready low after telegram", s[0], 1'b0);
            read_byte(got);
            chk("R3 received byte nibble order", got, v);
            rd(1'b1, s);
            chk("R3 ready after second read", s[0], 1'b1);
            chk("R9 one end pulse rx", irq_cnt - base, 1);
        end

        // R8 link receive acknowledge slot
        wr(1'b1, 4'b0001);
        recv_bits(8'h3C);
        rd(1'b1, s);
        chk("R8 in ack slot active", s[1], 1'b1);
        shift1(1'b1, bo);
        chk("R8 ack driven low", bo, 1'b0);
        read_byte(got);
        chk("R8 link rx data", got, 8'h3C);
        wr(1'b1, 4'b0101);
        recv_bits(8'hC3);
        shift1(1'b0, bo);
        chk("R8 ack suppressed", bo, 1'b1);
        read_byte(got);
        chk("R8 link rx data 2", got, 8'hC3);

        // R10 ready-fall source
        #0 tx_mode = 1'b1;
        wr(1'b1, 4'b1100);
        base = irq_cnt;
        wr(1'b0, 4'h5);
        wr(1'b0, 4'hA);
        repeat (2) @(posedge clk);
        chk("R10 no pulse on ready rise", irq_cnt - base, 0);
        start();
        repeat (2) @(posedge clk);
        chk("R10 pulse on ready fall", irq_cnt - base, 1);
        for (int i = 0; i < 8; i++) shift1(1'b0, bo);
        repeat (2) @(posedge clk);
        chk("R10 no pulse at telegram end", irq_cnt - base, 1);

        // R11 masked, both sources
        wr(1'b1, 4'b1110);
        base = irq_cnt;
        send(8'h81, got);
        wr(1'b1, 4'b1111);
        send(8'h18, got);
        repeat (2) @(posedge clk);
        chk("R11 masked no pulses", irq_cnt - base, 0);

        // R11 same-cycle mask write kills ready-fall pulse
        wr(1'b1, 4'b1100);
        wr(1'b0, 4'h7);
        wr(1'b0, 4'h7);
        base = irq_cnt;
        @(posedge clk); #1 tl_start = 1'b1;
        @(posedge clk); #1 tl_start = 1'b0;
        bus_ctl = 1'b1; bus_wr = 1'b1; bus_wdata = 4'b1110;
        @(posedge clk); #1 bus_wr = 1'b0; bus_ctl = 1'b0;
        for (int i = 0; i < 8; i++) shift1(1'b0, bo);
        repeat (2) @(posedge clk);
        chk("R11 same-cycle mask write", irq_cnt - base, 0);

        done_flag = 1;
        summary();
        $finish;
    end

endmodule